// File: doc/BRIEF.md
# Video Sync Input Qualifier

This block conditions the horizontal and vertical sync pins of an on-screen display controller. It runs in the dot-clock domain. Each pin passes through a two-stage synchroniser. A single polarity bit then maps both pins to an internal "active" level. The horizontal sync pulse is measured in dot clocks. At its trailing edge the block decides whether the line was valid. A valid line produces a one-cycle line-start pulse. A line that was too short produces a one-cycle error pulse instead.

Vertical sync has no edge detector of its own. Its level is sampled only at the trailing edge of a valid horizontal pulse. A frame start is reported when that sample is active and the previous valid sample was inactive. The frame-start pulse coincides with the line-start pulse of the qualifying line.

While horizontal sync is active, the block exposes an active flag that halts internal work and locks out video memory writes. A write request that arrives during the lockout is reported back as blocked. It is then held pending, with a busy indication, and granted on the first dot clock after the lockout ends.

Top module: `sync_qual_top`

## Requirements
- R1: With `pol_pos` = 0 both pins are active when low; with `pol_pos` = 1 both pins are active when high.
- R2: `hs_active` is high for exactly as many cycles as the horizontal pin was active, delayed by the two-stage synchroniser.
- R3: A horizontal pulse of at least 18 active cycles gives one `line_start` pulse, one cycle wide, in the cycle after `hs_active` falls.
- R4: A horizontal pulse shorter than 18 cycles gives one `hs_err` pulse in that same cycle position. It gives no `line_start` and no `frame_start`, and it leaves the stored vertical sample unchanged.
- R5: `frame_start` is raised together with `line_start` when the vertical level at that trailing edge is active and the previous valid sample was inactive.
- R6: A vertical level that stays active over several valid lines yields only one `frame_start` (leading edge only).
- R7: A one-cycle `wr_req` seen while `hs_active` is low gives one `wr_grant` in the next cycle and no `wr_blocked`.
- R8: A `wr_req` seen while `hs_active` is high gives one `wr_blocked` pulse in the next cycle. `wr_busy` stays high until the request is granted. Exactly one `wr_grant` follows, in the cycle after `hs_active` falls.
- R9: Synchronous reset drives every output low and clears the stored vertical sample to inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_pos | input | 1 | Sync polarity: 0 active-low, 1 active-high |
| hs_pin | input | 1 | Asynchronous horizontal sync pin |
| vs_pin | input | 1 | Asynchronous vertical sync pin |
| wr_req | input | 1 | One-cycle video memory write request |
| hs_active | output | 1 | Horizontal sync active; halts internal operation |
| line_start | output | 1 | One-cycle pulse at the trailing edge of a valid line |
| frame_start | output | 1 | One-cycle pulse with the qualifying line start |
| hs_err | output | 1 | One-cycle pulse at the trailing edge of a too-short pulse |
| wr_grant | output | 1 | One-cycle write grant |
| wr_blocked | output | 1 | One-cycle report that a request hit the lockout |
| wr_busy | output | 1 | A blocked request is pending |

## Verification
A write request blocked during a horizontal pulse is released in the very cycle that the trailing edge produces `line_start`, and possibly `frame_start`. Grant and line qualification therefore fall in the same cycle. The bench provokes this by raising a request in the middle of every long-enough pulse of a width sweep under both polarities. For each pulse it records the sample where `hs_active` drops. It then requires both `wr_grant` and `line_start` (or `hs_err`) exactly one sample later, each counted once.

// File: rtl/sync_qual_pkg.sv
package sync_qual_pkg;

    localparam int MIN_HS_W_DEF  = 18;
    localparam int SYNC_DEPTH_DEF = 2;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_pair_t;

    typedef enum logic {
        GATE_IDLE = 1'b0,
        GATE_PEND = 1'b1
    } gate_state_e;

    typedef struct packed {
        logic line_ok;
        logic line_bad;
        logic vs_level;
    } line_event_t;

    // Map a synchronised pin level to "active": positive polarity passes through.
    function automatic logic to_active(input logic lvl, input logic pos);
        return pos ? lvl : ~lvl;
    endfunction

endpackage

// File: rtl/sync_pin_sync.sv
module sync_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] rst_val,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[0] <= rst_val;
                    else     chain[0] <= d_async;
                end
            end else begin : g_rest
                always_ff @(posedge clk) begin
                    if (rst) chain[s] <= rst_val;
                    else     chain[s] <= chain[s-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/hs_width_meter.sv
module hs_width_meter #(
    parameter int MIN_W = 18
) (
    input  logic clk,
    input  logic rst,
    input  logic hs_act,
    input  logic vs_act,
    output sync_qual_pkg::line_event_t evt
);
    import sync_qual_pkg::*;

    localparam int CW = $clog2(MIN_W + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_W);

    logic [CW-1:0] width_cnt;
    logic          hs_prev;
    logic          trail;

    assign trail = hs_prev & ~hs_act;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_cnt <= '0;
            hs_prev   <= 1'b0;
            evt       <= '0;
        end else begin
            hs_prev <= hs_act;
            if (hs_act) begin
                if (width_cnt != LIMIT) width_cnt <= width_cnt + 1'b1;
            end else begin
                width_cnt <= '0;
            end
            evt.line_ok  <= trail & (width_cnt == LIMIT);
            evt.line_bad <= trail & (width_cnt != LIMIT);
            evt.vs_level <= vs_act;
        end
    end
endmodule

// File: rtl/frame_qualifier.sv
module frame_qualifier (
    input  logic clk,
    input  logic rst,
    input  sync_qual_pkg::line_event_t evt,
    output logic frame_pulse
);
    logic vs_sample;

    always_comb frame_pulse = evt.line_ok & evt.vs_level & ~vs_sample;

    always_ff @(posedge clk) begin
        if (rst)              vs_sample <= 1'b0;
        else if (evt.line_ok) vs_sample <= evt.vs_level;
    end
endmodule

// File: rtl/vram_write_gate.sv
module vram_write_gate (
    input  logic clk,
    input  logic rst,
    input  logic lockout,
    input  logic req,
    output logic grant,
    output logic blocked,
    output logic busy
);
    import sync_qual_pkg::*;

    gate_state_e state, state_nx;
    logic        want;

    always_comb begin
        want     = req | (state == GATE_PEND);
        state_nx = (want & lockout) ? GATE_PEND : GATE_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= GATE_IDLE;
            grant   <= 1'b0;
            blocked <= 1'b0;
        end else begin
            state   <= state_nx;
            grant   <= want & ~lockout;
            blocked <= req & lockout & (state == GATE_IDLE);
        end
    end

    assign busy = (state == GATE_PEND);
endmodule

// File: rtl/sync_qual_top.sv
module sync_qual_top #(
    parameter int MIN_HS_W   = sync_qual_pkg::MIN_HS_W_DEF,
    parameter int SYNC_DEPTH = sync_qual_pkg::SYNC_DEPTH_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic pol_pos,
    input  logic hs_pin,
    input  logic vs_pin,
    input  logic wr_req,
    output logic hs_active,
    output logic line_start,
    output logic frame_start,
    output logic hs_err,
    output logic wr_grant,
    output logic wr_blocked,
    output logic wr_busy
);
    import sync_qual_pkg::*;

    sync_pair_t  pins_s;
    sync_pair_t  idle_lvl;
    logic        hs_act, vs_act;
    line_event_t evt;
    logic        frame_pulse;

    // Reset the synchroniser to the inactive level of the current polarity.
    assign idle_lvl = '{hs: ~pol_pos, vs: ~pol_pos};

    sync_pin_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .rst_val (idle_lvl),
        .d_async ({hs_pin, vs_pin}),
        .q_sync  (pins_s)
    );

    assign hs_act = to_active(pins_s.hs, pol_pos);
    assign vs_act = to_active(pins_s.vs, pol_pos);

    hs_width_meter #(.MIN_W(MIN_HS_W)) u_meter (
        .clk    (clk),
        .rst    (rst),
        .hs_act (hs_act),
        .vs_act (vs_act),
        .evt    (evt)
    );

    frame_qualifier u_frame (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .frame_pulse (frame_pulse)
    );

    vram_write_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .lockout (hs_act),
        .req     (wr_req),
        .grant   (wr_grant),
        .blocked (wr_blocked),
        .busy    (wr_busy)
    );

    assign hs_active   = hs_act & ~rst;
    assign line_start  = evt.line_ok;
    assign hs_err      = evt.line_bad;
    assign frame_start = frame_pulse;
endmodule

// File: rtl/sync_qual_checker.sv
module sync_qual_checker (
    input logic clk,
    input logic rst,
    input logic hs_active,
    input logic line_start,
    input logic frame_start,
    input logic hs_err,
    input logic wr_grant,
    input logic wr_blocked,
    input logic wr_busy
);
    AST_LS_SINGLE:     assert property (@(posedge clk) disable iff (rst) line_start |=> !line_start);        // R3
    AST_ERR_NO_LS:     assert property (@(posedge clk) disable iff (rst) hs_err |-> !line_start);            // R4
    AST_FS_WITH_LS:    assert property (@(posedge clk) disable iff (rst) frame_start |-> line_start);        // R5
    AST_FS_SINGLE:     assert property (@(posedge clk) disable iff (rst) frame_start |=> !frame_start);      // R6
    AST_GRANT_FREE:    assert property (@(posedge clk) disable iff (rst) wr_grant |-> !$past(hs_active));    // R7
    AST_BLOCK_BUSY:    assert property (@(posedge clk) disable iff (rst) wr_blocked |-> wr_busy);            // R8
    AST_BUSY_NO_GRANT: assert property (@(posedge clk) disable iff (rst) wr_busy |-> !wr_grant);             // R8
    AST_BUSY_HOLD:     assert property (@(posedge clk) disable iff (rst) (wr_busy && hs_active) |=> wr_busy); // R8
endmodule

bind sync_qual_top sync_qual_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .hs_active   (hs_active),
    .line_start  (line_start),
    .frame_start (frame_start),
    .hs_err      (hs_err),
    .wr_grant    (wr_grant),
    .wr_blocked  (wr_blocked),
    .wr_busy     (wr_busy)
);

// File: tb/sync_qual_top_bench.sv
`timescale 1ns/1ps
module sync_qual_top_bench;
    localparam int MIN_W = 18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pol_pos = 1'b0;
    logic hs_pin = 1'b1, vs_pin = 1'b1, wr_req = 1'b0;
    logic hs_active, line_start, frame_start, hs_err, wr_grant, wr_blocked, wr_busy;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    sync_qual_top u_sync_qual_top (
        .clk(clk), .rst(rst), .pol_pos(pol_pos), .hs_pin(hs_pin), .vs_pin(vs_pin),
        .wr_req(wr_req), .hs_active(hs_active), .line_start(line_start),
        .frame_start(frame_start), .hs_err(hs_err), .wr_grant(wr_grant),
        .wr_blocked(wr_blocked), .wr_busy(wr_busy)
    );

    // Monitor: samples 1 ns after every rising edge.
    bit mon = 1'b0;
    int t = 0, t_fall = -1, t_ls = -1, t_err = -1, t_gnt = -1;
    int n_hs = 0, n_ls = 0, n_fs = 0, n_err = 0, n_gnt = 0, n_blk = 0, n_busy = 0;
    logic hs_q = 1'b0;

    always @(posedge clk) begin
        #1;
        if (mon) begin
            t++;
            if (hs_active) n_hs++;
            if (hs_q && !hs_active && t_fall < 0) t_fall = t;
            if (line_start)  begin n_ls++;  t_ls  = t; end
            if (hs_err)      begin n_err++; t_err = t; end
            if (frame_start) n_fs++;
            if (wr_grant)    begin n_gnt++; t_gnt = t; end
            if (wr_blocked)  n_blk++;
            if (wr_busy)     n_busy++;
            hs_q = hs_active;
        end
    end

    task automatic clear_mon();
        t = 0; t_fall = -1; t_ls = -1; t_err = -1; t_gnt = -1;
        n_hs = 0; n_ls = 0; n_fs = 0; n_err = 0; n_gnt = 0; n_blk = 0; n_busy = 0;
        hs_q = 1'b0;
    endtask

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic lvl(bit active);
        return pol_pos ? active : ~active;
    endfunction

    bit vs_model = 1'b0;

    task automatic do_reset(bit pol, bit vs_act);
        @(negedge clk);
        rst = 1'b1; pol_pos = pol;
        hs_pin = lvl(1'b0); vs_pin = lvl(vs_act); wr_req = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        vs_model = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // One horizontal pulse of n cycles, vertical level vs_act, optional mid-pulse request.
    task automatic run_line(int n, bit vs_act, bit with_wr);
        bit valid, exp_fs;
        valid  = (n >= MIN_W);
        exp_fs = valid && vs_act && !vs_model;
        clear_mon();
        mon = 1'b1;
        @(negedge clk);
        vs_pin = lvl(vs_act);
        hs_pin = lvl(1'b1);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (with_wr && k == 3) wr_req = 1'b1;
            else                   wr_req = 1'b0;
        end
        hs_pin = lvl(1'b0);
        wr_req = 1'b0;
        repeat (8) @(negedge clk);
        mon = 1'b0;
        check($sformatf("R1/R2 width n=%0d pol=%0d", n, pol_pos), n_hs, n);
        check($sformatf("R3 line_start count n=%0d", n), n_ls, valid ? 1 : 0);
        check($sformatf("R4 hs_err count n=%0d", n), n_err, valid ? 0 : 1);
        if (valid) check("R3 line_start timing", t_ls, t_fall + 1);
        else       check("R4 hs_err timing", t_err, t_fall + 1);
        check($sformatf("R5/R6 frame_start n=%0d vs=%0d prev=%0d", n, vs_act, vs_model),
              n_fs, exp_fs ? 1 : 0);
        if (with_wr) begin
            check("R8 blocked count", n_blk, 1);
            check("R8 grant count", n_gnt, 1);
            check("R8 grant in line-start cycle", t_gnt, t_fall + 1);
            check("R8 busy seen", (n_busy > 0) ? 1 : 0, 1);
        end
        if (valid) vs_model = vs_act;
    endtask

    task automatic idle_write();
        clear_mon();
        mon = 1'b1;
        @(negedge clk); wr_req = 1'b1;
        @(negedge clk); wr_req = 1'b0;
        repeat (4) @(negedge clk);
        mon = 1'b0;
        check("R7 idle grant count", n_gnt, 1);
        check("R7 idle grant timing", t_gnt, 2);
        check("R7 idle no blocked", n_blk, 0);
        check("R7 idle no busy", n_busy, 0);
    endtask

    initial begin
        do_reset(1'b0, 1'b0);
        // R9: reset state at the ports
        check("R9 outputs after reset",
              int'({hs_active, line_start, frame_start, hs_err, wr_grant, wr_blocked, wr_busy}), 0);
        for (int p = 0; p < 2; p++) begin
            do_reset(p[0], 1'b0);
            idle_write();
            for (int n = 1; n <= 24; n++) begin
                run_line(n, n[0] ^ n[2], n >= 6);
            end
            // R6: vertical held active over several valid lines -> one frame start
            run_line(20, 1'b0, 1'b0);
            run_line(20, 1'b1, 1'b1);
            run_line(20, 1'b1, 1'b0);
            run_line(22, 1'b1, 1'b1);
            // R4: short pulse with vertical changing must not disturb stored sample
            run_line(10, 1'b0, 1'b1);
            run_line(19, 1'b1, 1'b0);
            idle_write();
        end
        // R9: reset with vertical already active; sample cleared to inactive
        do_reset(1'b1, 1'b1);
        check("R9 no frame_start after reset", int'(frame_start), 0);
        run_line(18, 1'b1, 1'b0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule